// File: doc/BRIEF.md
# Load-Delay Dependency Classifier

This block decides how the instruction that sits right behind a pending load touches that load's destination register. It receives the 5-bit index of the register the load will write and the 32-bit instruction word that follows the load. It returns a 2-bit code: no relation, read and write, read only, or write only. A pipeline controller or sequencer uses the code to pick the right way to resolve the load-delay slot. For example, it can let the old value be seen, drop the late load result, or run the slot as normal.

The classification is pure decode logic. A parameter selects whether the result is available in the same cycle or one clock later from a register stage. Field positions are fixed: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function code in bits 5:0. For coprocessor words, the move sub-operation is taken from the rs field. Conditional branches always report no relation. The caller can thus treat a compare-and-branch after a load as independent of the load.

Top module: `ldc_classifier`

## Requirements
- R1: The output codes are 0 = no relation, 1 = read and write, 2 = read only, 3 = write only. An all-zero instruction word always gives 0, whatever the pending register is.
- R2: Opcode 0 with function 0x20–0x27, 0x2A, 0x2B, 0x04, 0x06 or 0x07 gives these codes. A match on rd together with a match on rs or rt gives 1. A match on rs or rt only gives 2. A match on rd only gives 3.
- R3: Opcode 0 with function 0x00, 0x02 or 0x03 (constant shifts) uses rt as the only source and rd as the destination. A match on the rs field has no effect.
- R4: Opcode 0, function 0x08 gives 2 on an rs match. Opcode 0, function 0x09 reads rs and writes rd, and combines them as in R2.
- R5: Opcode 0 with function 0x10 or 0x12 gives 3 on an rd match. Function 0x11 or 0x13 gives 2 on an rs match. Function 0x18–0x1B gives 2 on an rs or rt match. No other field matters for these functions.
- R6: Opcodes 0x01, 0x02 and 0x04–0x07 always give 0, even when register fields match.
- R7: Opcode 0x03 gives 3 when the pending register is the link register (index 31 by default), and 0 otherwise.
- R8: Opcodes 0x08–0x0E and loads 0x20, 0x21, 0x23, 0x24, 0x25 read rs and write rt, and combine them as in R2. Opcode 0x0F gives 3 on an rt match only.
- R9: Opcodes 0x22 and 0x26 give 3 on an rt match, even when rs matches too. Otherwise they give 2 on an rs match.
- R10: Stores 0x28, 0x29, 0x2A, 0x2B, 0x2E give 2 on an rt or rs match. Coprocessor load/store 0x32 and 0x3A give 2 on an rs match only.
- R11: Opcode 0x10, and opcode 0x12 only when the function field is 0, select by the rs field. Values 0x00 and 0x02 give 3 on an rt match. Values 0x04 and 0x06 give 2 on an rt match. Opcode 0x12 with a nonzero function field gives 0.
- R12: Every opcode not named above gives 0. Pending register 0 is compared like any other index.
- R13: With OUT_REG=1, out_valid and dep_code appear on the clock edge after in_valid. When in_valid is low, dep_code holds its value. Reset clears out_valid and dep_code to 0. With OUT_REG=0, out_valid follows in_valid and dep_code is the decode result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pending register and instruction word are valid |
| pend_reg | input | 5 | Destination register index of the pending load |
| instr | input | 32 | Instruction word following the load |
| out_valid | output | 1 | dep_code carries a result |
| dep_code | output | 2 | Dependency code (0 none, 1 read+write, 2 read, 3 write) |

## Verification
The bench builds two copies of the block. The default copy uses OUT_REG=1, and a scoreboard checks it against expected codes one cycle late. This copy also shows the reset state and the hold behaviour while in_valid is low. A second copy uses OUT_REG=0 and is checked in the same cycle on every vector, so both variants selected by the parameter are covered. The vectors cover every opcode group, each priority case (rd with source, rt over rs for unaligned loads), the branch exemption, the link register match, and the all-zero word against a nonzero shift that decodes to the same fields.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int OP_W    = 6;
  localparam int OP_LSB  = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  typedef enum logic [1:0] {
    DEP_NONE = 2'd0,
    DEP_RW   = 2'd1,
    DEP_RD   = 2'd2,
    DEP_WR   = 2'd3
  } dep_t;

  // How an instruction class uses its register fields
  typedef enum logic [3:0] {
    USE_NONE,
    USE_ALU_R,     // src rs|rt, dst rd
    USE_SHIFT_C,   // src rt, dst rd
    USE_SRC_RS,    // src rs
    USE_JUMP_LINK, // src rs, dst rd
    USE_DST_RD,    // dst rd
    USE_SRC_RSRT,  // src rs|rt
    USE_IMM,       // src rs, dst rt
    USE_DST_RT,    // dst rt
    USE_SRC_RT,    // src rt
    USE_PART_LD,   // dst rt wins over src rs
    USE_LINK       // dst fixed link register
  } use_t;

  typedef struct packed {
    logic rs;
    logic rt;
    logic rd;
    logic link;
  } hit_t;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_JAL     = 6'h03;
  localparam logic [5:0] OPC_UPPER   = 6'h0F;
  localparam logic [5:0] OPC_COP0    = 6'h10;
  localparam logic [5:0] OPC_COP2    = 6'h12;

  function automatic dep_t combine(input logic src, input logic dst);
    if (src && dst)  return DEP_RW;
    else if (src)    return DEP_RD;
    else if (dst)    return DEP_WR;
    else             return DEP_NONE;
  endfunction
endpackage

// File: rtl/ldc_field_match.sv
module ldc_field_match
  import ldc_pkg::*;
#(
  parameter int LINK_IDX = 31
) (
  input  logic [REG_W-1:0]   pend_reg,
  input  logic [INSTR_W-1:0] instr,
  output hit_t               hits,
  output logic [OP_W-1:0]    opcode,
  output logic [5:0]         func,
  output logic [REG_W-1:0]   sub_op,
  output logic               zero_word
);
  logic [REG_W-1:0] f_rs, f_rt, f_rd;

  always_comb begin
    opcode    = instr[OP_LSB +: OP_W];
    f_rs      = instr[RS_LSB +: REG_W];
    f_rt      = instr[RT_LSB +: REG_W];
    f_rd      = instr[RD_LSB +: REG_W];
    func      = instr[5:0];
    sub_op    = f_rs;
    zero_word = (instr == '0);
    hits.rs   = (f_rs == pend_reg);
    hits.rt   = (f_rt == pend_reg);
    hits.rd   = (f_rd == pend_reg);
    hits.link = (pend_reg == REG_W'(LINK_IDX));
  end
endmodule

// File: rtl/ldc_use_decode.sv
module ldc_use_decode
  import ldc_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [5:0]       func,
  input  logic [REG_W-1:0] sub_op,
  output use_t             use_cls
);
  use_t cop_cls;

  always_comb begin
    case (sub_op)
      5'h00, 5'h02: cop_cls = USE_DST_RT;
      5'h04, 5'h06: cop_cls = USE_SRC_RT;
      default:      cop_cls = USE_NONE;
    endcase
  end

  always_comb begin
    use_cls = USE_NONE;
    case (opcode)
      OPC_SPECIAL: begin
        case (func)
          6'h00, 6'h02, 6'h03:               use_cls = USE_SHIFT_C;
          6'h08, 6'h11, 6'h13:               use_cls = USE_SRC_RS;
          6'h09:                             use_cls = USE_JUMP_LINK;
          6'h10, 6'h12:                      use_cls = USE_DST_RD;
          6'h18, 6'h19, 6'h1A, 6'h1B:        use_cls = USE_SRC_RSRT;
          6'h04, 6'h06, 6'h07,
          6'h20, 6'h21, 6'h22, 6'h23,
          6'h24, 6'h25, 6'h26, 6'h27,
          6'h2A, 6'h2B:                      use_cls = USE_ALU_R;
          default:                           use_cls = USE_NONE;
        endcase
      end
      OPC_JAL:                               use_cls = USE_LINK;
      6'h08, 6'h09, 6'h0A, 6'h0B,
      6'h0C, 6'h0D, 6'h0E,
      6'h20, 6'h21, 6'h23, 6'h24, 6'h25:     use_cls = USE_IMM;
      OPC_UPPER:                             use_cls = USE_DST_RT;
      OPC_COP0:                              use_cls = cop_cls;
      OPC_COP2:                              use_cls = (func == 6'h00) ? cop_cls : USE_NONE;
      6'h22, 6'h26:                          use_cls = USE_PART_LD;
      6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:     use_cls = USE_SRC_RSRT;
      6'h32, 6'h3A:                          use_cls = USE_SRC_RS;
      default:                               use_cls = USE_NONE;
    endcase
  end
endmodule

// File: rtl/ldc_dep_resolve.sv
module ldc_dep_resolve
  import ldc_pkg::*;
(
  input  use_t  use_cls,
  input  hit_t  hits,
  input  logic  zero_word,
  output dep_t  dep
);
  always_comb begin
    case (use_cls)
      USE_ALU_R:     dep = combine(hits.rs | hits.rt, hits.rd);
      USE_SHIFT_C:   dep = combine(hits.rt, hits.rd);
      USE_SRC_RS:    dep = combine(hits.rs, 1'b0);
      USE_JUMP_LINK: dep = combine(hits.rs, hits.rd);
      USE_DST_RD:    dep = combine(1'b0, hits.rd);
      USE_SRC_RSRT:  dep = combine(hits.rs | hits.rt, 1'b0);
      USE_IMM:       dep = combine(hits.rs, hits.rt);
      USE_DST_RT:    dep = combine(1'b0, hits.rt);
      USE_SRC_RT:    dep = combine(hits.rt, 1'b0);
      USE_PART_LD:   dep = hits.rt ? DEP_WR : combine(hits.rs, 1'b0);
      USE_LINK:      dep = combine(1'b0, hits.link);
      default:       dep = DEP_NONE;
    endcase
    if (zero_word) dep = DEP_NONE;
  end
endmodule

// File: rtl/ldc_out_stage.sv
module ldc_out_stage #(
  parameter bit OUT_REG = 1'b1,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] code_in,
  output logic              out_valid,
  output logic [CODE_W-1:0] code_out
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          code_out  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) code_out <= code_in;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign code_out  = code_in;
    end
  endgenerate
endmodule

// File: rtl/ldc_classifier.sv
module ldc_classifier
  import ldc_pkg::*;
#(
  parameter bit OUT_REG  = 1'b1,
  parameter int LINK_IDX = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [4:0]  pend_reg,
  input  logic [31:0] instr,
  output logic        out_valid,
  output logic [1:0]  dep_code
);
  hit_t             hits;
  logic [OP_W-1:0]  opcode;
  logic [5:0]       func;
  logic [REG_W-1:0] sub_op;
  logic             zero_word;
  use_t             use_cls;
  dep_t             dep;

  ldc_field_match #(.LINK_IDX(LINK_IDX)) u_match (
    .pend_reg (pend_reg),
    .instr    (instr),
    .hits     (hits),
    .opcode   (opcode),
    .func     (func),
    .sub_op   (sub_op),
    .zero_word(zero_word)
  );

  ldc_use_decode u_decode (
    .opcode (opcode),
    .func   (func),
    .sub_op (sub_op),
    .use_cls(use_cls)
  );

  ldc_dep_resolve u_resolve (
    .use_cls  (use_cls),
    .hits     (hits),
    .zero_word(zero_word),
    .dep      (dep)
  );

  ldc_out_stage #(.OUT_REG(OUT_REG), .CODE_W(2)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .code_in  (dep),
    .out_valid(out_valid),
    .code_out (dep_code)
  );
endmodule

// File: rtl/ldc_classifier_chk.sv
module ldc_classifier_chk #(
  parameter bit OUT_REG  = 1'b1,
  parameter int LINK_IDX = 31
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [4:0]  pend_reg,
  input logic [31:0] instr,
  input logic        out_valid,
  input logic [1:0]  dep_code
);
  // Inputs aligned with the cycle in which their result is on dep_code
  logic        al_v;
  logic [4:0]  al_p;
  logic [31:0] al_i;

  generate
    if (OUT_REG) begin : g_lag
      always_ff @(posedge clk) begin
        if (rst) begin
          al_v <= 1'b0;
          al_p <= '0;
          al_i <= '0;
        end else begin
          al_v <= in_valid;
          if (in_valid) begin
            al_p <= pend_reg;
            al_i <= instr;
          end
        end
      end
    end else begin : g_now
      always_comb begin
        al_v = in_valid;
        al_p = pend_reg;
        al_i = instr;
      end
    end
  endgenerate

  logic [5:0] c_op, c_fn;
  logic [4:0] c_rs, c_rt;
  assign c_op = al_i[31:26];
  assign c_rs = al_i[25:21];
  assign c_rt = al_i[20:16];
  assign c_fn = al_i[5:0];

  a_r13_valid_align: assert property (@(posedge clk) disable iff (rst)
    out_valid == al_v);

  a_r1_zero_word: assert property (@(posedge clk) disable iff (rst)
    (al_v && al_i == 32'd0) |-> dep_code == 2'd0);

  a_r6_branch_indep: assert property (@(posedge clk) disable iff (rst)
    (al_v && (c_op == 6'h01 || c_op == 6'h02 || (c_op >= 6'h04 && c_op <= 6'h07)))
      |-> dep_code == 2'd0);

  a_r7_link: assert property (@(posedge clk) disable iff (rst)
    (al_v && c_op == 6'h03) |-> dep_code == ((al_p == 5'(LINK_IDX)) ? 2'd3 : 2'd0));

  a_r9_partial_dest: assert property (@(posedge clk) disable iff (rst)
    (al_v && (c_op == 6'h22 || c_op == 6'h26) && c_rt == al_p) |-> dep_code == 2'd3);

  a_r10_store_read: assert property (@(posedge clk) disable iff (rst)
    (al_v && (c_op == 6'h28 || c_op == 6'h29 || c_op == 6'h2A || c_op == 6'h2B || c_op == 6'h2E))
      |-> (dep_code == 2'd0 || dep_code == 2'd2));

  a_r11_move_from: assert property (@(posedge clk) disable iff (rst)
    (al_v && c_op == 6'h10 && c_rs == 5'h00 && c_rt == al_p) |-> dep_code == 2'd3);

  a_r12_unlisted: assert property (@(posedge clk) disable iff (rst)
    (al_v && (c_op == 6'h11 || (c_op >= 6'h13 && c_op <= 6'h1F) || c_op == 6'h3F))
      |-> dep_code == 2'd0);

  a_r5_hilo_from: assert property (@(posedge clk) disable iff (rst)
    (al_v && c_op == 6'h00 && (c_fn == 6'h10 || c_fn == 6'h12))
      |-> (dep_code == 2'd0 || dep_code == 2'd3));
endmodule

bind ldc_classifier ldc_classifier_chk #(.OUT_REG(OUT_REG), .LINK_IDX(LINK_IDX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .pend_reg (pend_reg),
  .instr    (instr),
  .out_valid(out_valid),
  .dep_code (dep_code)
);

// File: tb/tb_ldc_classifier.sv
module tb_ldc_classifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  pend = '0;
  logic [31:0] instr = '0;
  logic        out_valid, out_valid_c;
  logic [1:0]  dep_code, dep_code_c;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ldc_classifier #(.OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pend_reg(pend), .instr(instr),
    .out_valid(out_valid), .dep_code(dep_code)
  );

  ldc_classifier #(.OUT_REG(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pend_reg(pend), .instr(instr),
    .out_valid(out_valid_c), .dep_code(dep_code_c)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sa, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] p, input logic [31:0] w, input logic [1:0] e,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    pend     = p;
    instr    = w;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    check({tag, " (same-cycle copy)"}, dep_code_c, e);
  endtask

  // Scoreboard monitor for the registered copy
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R13 unexpected out_valid", 1, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, dep_code, e);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset out_valid", out_valid, 0);
    check("R13 reset dep_code", dep_code, 0);
    rst = 1'b0;

    // R1 zero word vs nonzero shift with the same register fields
    send(5'd0, 32'h0, 2'd0, "R1 zero word");
    send(5'd0, enc_r(5'd0, 5'd0, 5'd0, 5'd1, 6'h00), 2'd1, "R3 shift rd+rt on r0");
    // R2 register ALU / variable shifts
    send(5'd5, enc_r(5'd5, 5'd6, 5'd5, 5'd0, 6'h21), 2'd1, "R2 rd+rs");
    send(5'd6, enc_r(5'd5, 5'd6, 5'd7, 5'd0, 6'h2A), 2'd2, "R2 rt only");
    send(5'd8, enc_r(5'd5, 5'd6, 5'd8, 5'd0, 6'h27), 2'd3, "R2 rd only");
    send(5'd9, enc_r(5'd5, 5'd6, 5'd8, 5'd0, 6'h20), 2'd0, "R2 no match");
    send(5'd3, enc_r(5'd3, 5'd4, 5'd3, 5'd0, 6'h04), 2'd1, "R2 var shift rd+rs");
    // R3 constant shifts ignore rs
    send(5'd2, enc_r(5'd2, 5'd9, 5'd2, 5'd3, 6'h02), 2'd3, "R3 rd only");
    send(5'd2, enc_r(5'd2, 5'd9, 5'd4, 5'd3, 6'h03), 2'd0, "R3 rs ignored");
    send(5'd9, enc_r(5'd1, 5'd9, 5'd4, 5'd3, 6'h00), 2'd2, "R3 rt source");
    // R4 register jumps
    send(5'd4, enc_r(5'd4, 5'd0, 5'd0, 5'd0, 6'h08), 2'd2, "R4 jr rs");
    send(5'd4, enc_r(5'd1, 5'd4, 5'd4, 5'd0, 6'h08), 2'd0, "R4 jr other fields");
    send(5'd4, enc_r(5'd4, 5'd0, 5'd4, 5'd0, 6'h09), 2'd1, "R4 jalr rs+rd");
    send(5'd31, enc_r(5'd4, 5'd0, 5'd31, 5'd0, 6'h09), 2'd3, "R4 jalr rd");
    // R5 hi/lo and multiply/divide
    send(5'd7, enc_r(5'd0, 5'd0, 5'd7, 5'd0, 6'h10), 2'd3, "R5 from-hi rd");
    send(5'd7, enc_r(5'd7, 5'd0, 5'd0, 5'd0, 6'h13), 2'd2, "R5 to-lo rs");
    send(5'd2, enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'h18), 2'd2, "R5 mult rt");
    send(5'd2, enc_r(5'd1, 5'd3, 5'd2, 5'd0, 6'h1A), 2'd0, "R5 div rd ignored");
    // R6 branches
    send(5'd3, enc_i(6'h04, 5'd3, 5'd3, 16'h0010), 2'd0, "R6 beq match");
    send(5'd3, enc_i(6'h01, 5'd3, 5'h10, 16'h0010), 2'd0, "R6 regimm match");
    send(5'd3, enc_i(6'h07, 5'd3, 5'd0, 16'h0010), 2'd0, "R6 bgtz match");
    send(5'd31, {6'h02, 26'h0123456}, 2'd0, "R6 plain jump");
    // R7 link
    send(5'd31, {6'h03, 26'h0123456}, 2'd3, "R7 link hit");
    send(5'd30, {6'h03, 26'h0123456}, 2'd0, "R7 link miss");
    // R8 immediate ALU, loads, upper-immediate
    send(5'd4, enc_i(6'h09, 5'd4, 5'd4, 16'h0001), 2'd1, "R8 imm rs+rt");
    send(5'd5, enc_i(6'h0D, 5'd4, 5'd5, 16'h00FF), 2'd3, "R8 imm rt");
    send(5'd4, enc_i(6'h0A, 5'd4, 5'd5, 16'h00FF), 2'd2, "R8 imm rs");
    send(5'd3, enc_i(6'h23, 5'd3, 5'd3, 16'h0004), 2'd1, "R8 load rs+rt");
    send(5'd6, enc_i(6'h0F, 5'd0, 5'd6, 16'h1234), 2'd3, "R8 upper rt");
    send(5'd6, enc_i(6'h0F, 5'd6, 5'd1, 16'h1234), 2'd0, "R8 upper rs ignored");
    // R9 partial loads
    send(5'd3, enc_i(6'h22, 5'd3, 5'd3, 16'h0001), 2'd3, "R9 rt over rs");
    send(5'd3, enc_i(6'h26, 5'd3, 5'd8, 16'h0002), 2'd2, "R9 rs only");
    // R10 stores and coprocessor load/store
    send(5'd5, enc_i(6'h2B, 5'd1, 5'd5, 16'h0000), 2'd2, "R10 store rt");
    send(5'd5, enc_i(6'h28, 5'd5, 5'd1, 16'h0000), 2'd2, "R10 store rs");
    send(5'd5, enc_i(6'h32, 5'd1, 5'd5, 16'h0000), 2'd0, "R10 cop load rt ignored");
    send(5'd5, enc_i(6'h3A, 5'd5, 5'd1, 16'h0000), 2'd2, "R10 cop store rs");
    // R11 coprocessor moves
    send(5'd9, {6'h10, 5'h00, 5'd9, 5'd12, 11'd0}, 2'd3, "R11 cop0 move-from");
    send(5'd9, {6'h10, 5'h04, 5'd9, 5'd12, 11'd0}, 2'd2, "R11 cop0 move-to");
    send(5'd9, {6'h12, 5'h02, 5'd9, 5'd3, 11'd0}, 2'd3, "R11 cop2 control-from");
    send(5'd9, {6'h12, 5'h00, 5'd9, 5'd3, 5'd0, 6'h01}, 2'd0, "R11 cop2 nonzero func");
    // R12 unlisted opcodes
    send(5'd7, enc_i(6'h3F, 5'd7, 5'd7, 16'h0000), 2'd0, "R12 unlisted opcode");
    send(5'd7, enc_r(5'd7, 5'd7, 5'd7, 5'd0, 6'h3E), 2'd0, "R12 unlisted func");
    send(5'd0, enc_i(6'h2B, 5'd0, 5'd3, 16'h0000), 2'd2, "R12 pending r0 compared");
    send(5'd8, enc_r(5'd1, 5'd2, 5'd8, 5'd0, 6'h25), 2'd3, "R2 last vector");

    // R13 hold while idle
    @(negedge clk);
    in_valid = 1'b0;
    pend     = 5'd0;
    instr    = 32'h0;
    @(negedge clk);
    check("R13 idle out_valid", out_valid, 0);
    check("R13 idle hold dep_code", dep_code, 3);
    check("R13 same-cycle valid follows", out_valid_c, 0);
    repeat (2) @(negedge clk);
    check("R13 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule